// File: doc/BRIEF.md
# Slot DMA Priority Daisy Chain Arbiter

This block arbitrates access to a shared expansion bus among a row of card slots. The slots are linked by a priority chain that runs from the head slot to the tail. Each slot reports three things: whether a card is fitted, whether that card takes part in DMA, and whether it is asking for the bus. The chain signal enters at the head. A fitted card that does not do DMA passes it straight through. A DMA card that is requesting stops it. An empty slot breaks it. A DMA card wins the bus only while its own chain input is still asserted, so the nearest requester to the head always wins.

The decision is made again at every bus cycle. The enclosing bus timing pulses `cycle_start` once per byte transfer, at the boundary that ends the arbitration phase and begins the access phase. The winner is latched there and held for the whole access phase. This gives a losing card a full phase to turn its drivers off. No transfer is ever locked across cycles. A card nearer the head therefore takes over from a farther one on the very next byte. A latched grant drives the shared active-low DMA line and halts the host CPU. When nobody is granted, the host CPU keeps the bus.

All pins are level control signals, so there is no valid/ready handshake and no back-pressure. The per-slot chain inputs and outputs are brought out so that the chain state can be observed.

Top module: `slot_dma_chain`

## Requirements
- R1: During and after reset, before the first `cycle_start`, `grant` is all zero, `dma_n` is 1 and `cpu_halt` is 0.
- R2: Bit 0 is the head slot and has the highest priority. Its chain input is always 1. At a `cycle_start` edge, `grant` takes the one-hot bit of the lowest-index slot that has a card fitted, has `slot_dma_card`=1, has `slot_req`=1 and has `chain_in`=1.
- R3: `grant` changes only on a clock edge where `cycle_start` is 1. At every other edge it holds its value, whatever the inputs do.
- R4: `grant` is always one-hot or all zero.
- R5: A fitted card with `slot_dma_card`=0 copies its `chain_in` to its `chain_out`. Its `slot_req` has no effect on the grant or on the chain.
- R6: A slot with `slot_present`=0 drives `chain_out`=0. No slot beyond it can be granted.
- R7: A fitted DMA card with `slot_req`=1 drives `chain_out`=0. In every other case a fitted DMA card copies `chain_in` to `chain_out`.
- R8: `dma_n` is 0 exactly when some `grant` bit is 1. `cpu_halt` is always the inverse of `dma_n`.
- R9: If a slot nearer the head requests while a farther slot holds the grant, the nearer slot takes the grant at the next `cycle_start`.
- R10: At a `cycle_start` with no eligible requester, `grant` becomes all zero, so the host CPU owns the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | Phase boundary strobe, one per bus cycle |
| slot_present | input | NUM_SLOTS | Card fitted in each slot |
| slot_dma_card | input | NUM_SLOTS | Fitted card takes part in DMA |
| slot_req | input | NUM_SLOTS | Bus request from each card |
| chain_in | output | NUM_SLOTS | Chain signal arriving at each slot |
| chain_out | output | NUM_SLOTS | Chain signal leaving each slot |
| grant | output | NUM_SLOTS | Registered one-hot bus grant |
| dma_n | output | 1 | Shared active-low DMA line |
| cpu_halt | output | 1 | Host CPU halt |

## Verification
The bench targets the head-wins rule with several requesters at once. A design that reversed the priority would grant the highest index instead. A gap in the row of slots is placed ahead of a requester; a design that skipped empty slots would grant a card beyond the break. A pass-through card asserts its request; a design that honoured that request would block the chain or grant a non-DMA card. Requests are changed between strobes and a nearer card asks while a farther one holds the bus, which exposes a grant that follows the inputs without the strobe or one that stays locked to the current owner.

// File: rtl/slot_dma_pkg.sv
package slot_dma_pkg;
  localparam int unsigned DEFAULT_SLOTS = 8;

  typedef enum logic [1:0] {
    LINK_EMPTY = 2'd0,
    LINK_PASS  = 2'd1,
    LINK_IDLE  = 2'd2,
    LINK_TAKE  = 2'd3
  } link_mode_e;

  function automatic link_mode_e classify_link(input logic present,
                                               input logic dma_card,
                                               input logic req);
    if (!present)
      return LINK_EMPTY;
    else if (!dma_card)
      return LINK_PASS;
    else if (req)
      return LINK_TAKE;
    else
      return LINK_IDLE;
  endfunction
endpackage

// File: rtl/slot_chain_link.sv
module slot_chain_link
  import slot_dma_pkg::*;
(
  input  logic link_in,
  input  logic present,
  input  logic dma_card,
  input  logic req,
  output logic link_out,
  output logic eligible
);
  link_mode_e mode;

  always_comb begin
    mode = classify_link(present, dma_card, req);
    link_out = 1'b0;
    eligible = 1'b0;
    unique case (mode)
      LINK_EMPTY: link_out = 1'b0;
      LINK_PASS:  link_out = link_in;
      LINK_IDLE:  link_out = link_in;
      LINK_TAKE: begin
        link_out = 1'b0;
        eligible = link_in;
      end
      default: link_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/slot_grant_reg.sv
module slot_grant_reg #(
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cycle_start,
  input  logic [NUM_SLOTS-1:0] eligible,
  output logic [NUM_SLOTS-1:0] grant
);
  logic [NUM_SLOTS-1:0] winner;
  logic [NUM_SLOTS:0]   taken;

  // Defensive first-set pick; the chain already leaves at most one eligible.
  assign taken[0] = 1'b0;
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_pick
    assign winner[i]  = eligible[i] & ~taken[i];
    assign taken[i+1] = taken[i] | eligible[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      grant <= '0;
    else if (cycle_start)
      grant <= winner;
  end
endmodule

// File: rtl/slot_dma_chain.sv
module slot_dma_chain
  import slot_dma_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = DEFAULT_SLOTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cycle_start,
  input  logic [NUM_SLOTS-1:0] slot_present,
  input  logic [NUM_SLOTS-1:0] slot_dma_card,
  input  logic [NUM_SLOTS-1:0] slot_req,
  output logic [NUM_SLOTS-1:0] chain_in,
  output logic [NUM_SLOTS-1:0] chain_out,
  output logic [NUM_SLOTS-1:0] grant,
  output logic                 dma_n,
  output logic                 cpu_halt
);
  logic [NUM_SLOTS-1:0] eligible;

  assign chain_in[0] = 1'b1;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    slot_chain_link u_link (
      .link_in  (chain_in[s]),
      .present  (slot_present[s]),
      .dma_card (slot_dma_card[s]),
      .req      (slot_req[s]),
      .link_out (chain_out[s]),
      .eligible (eligible[s])
    );
    if (s + 1 < NUM_SLOTS) begin : g_next
      assign chain_in[s+1] = chain_out[s];
    end
  end

  slot_grant_reg #(.NUM_SLOTS(NUM_SLOTS)) u_grant (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_start (cycle_start),
    .eligible    (eligible),
    .grant       (grant)
  );

  assign dma_n    = ~(|grant);
  assign cpu_halt = |grant;
endmodule

// File: rtl/slot_dma_chain_chk.sv
module slot_dma_chain_chk #(
  parameter int unsigned NUM_SLOTS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cycle_start,
  input logic [NUM_SLOTS-1:0] slot_present,
  input logic [NUM_SLOTS-1:0] slot_dma_card,
  input logic [NUM_SLOTS-1:0] slot_req,
  input logic [NUM_SLOTS-1:0] chain_in,
  input logic [NUM_SLOTS-1:0] chain_out,
  input logic [NUM_SLOTS-1:0] grant,
  input logic                 dma_n,
  input logic                 cpu_halt
);
  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> $stable(grant));

  // R8
  dma_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_n == (grant == '0)) && (cpu_halt != dma_n));

  // R2
  head_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_in[0]);

  // R2
  grant_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> ((grant & ~$past(slot_req & slot_dma_card & slot_present & chain_in)) == '0));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_chk
    // R6
    empty_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_present[i] |-> !chain_out[i]);
    // R7
    req_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_present[i] && slot_dma_card[i] && slot_req[i]) |-> !chain_out[i]);
    // R5
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_present[i] && !slot_dma_card[i]) |-> (chain_out[i] == chain_in[i]));
  end
endmodule

bind slot_dma_chain slot_dma_chain_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cycle_start   (cycle_start),
  .slot_present  (slot_present),
  .slot_dma_card (slot_dma_card),
  .slot_req      (slot_req),
  .chain_in      (chain_in),
  .chain_out     (chain_out),
  .grant         (grant),
  .dma_n         (dma_n),
  .cpu_halt      (cpu_halt)
);

// File: tb/slot_dma_chain_tb.sv
module slot_dma_chain_tb;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cycle_start = 1'b0;
  logic [N-1:0] slot_present = '1;
  logic [N-1:0] slot_dma_card = '1;
  logic [N-1:0] slot_req = '0;
  logic [N-1:0] chain_in, chain_out, grant;
  logic         dma_n, cpu_halt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_dma_chain #(.NUM_SLOTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .slot_present(slot_present), .slot_dma_card(slot_dma_card),
    .slot_req(slot_req), .chain_in(chain_in), .chain_out(chain_out),
    .grant(grant), .dma_n(dma_n), .cpu_halt(cpu_halt)
  );

  // Expected winner from the requirement text: walk from the head.
  function automatic logic [N-1:0] expect_grant(input logic [N-1:0] p,
                                                input logic [N-1:0] d,
                                                input logic [N-1:0] r);
    logic open = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (!p[i]) return '0;
      if (d[i] && r[i]) return open ? (N'(1) << i) : '0;
    end
    return '0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) cycle_start = 1'b1;
    @(negedge clk) cycle_start = 1'b0;
  endtask

  task automatic t_reset();
    check(grant == '0, "R1 grant", grant, '0);
    check(dma_n == 1'b1 && cpu_halt == 1'b0, "R1 dma_n/halt", {dma_n, cpu_halt}, 2'b10);
  endtask

  task automatic t_single();
    slot_req = 8'b0000_1000;
    strobe();
    check(grant == 8'b0000_1000, "R2 single", grant, 8'b0000_1000);
    check(dma_n == 1'b0 && cpu_halt == 1'b1, "R8 active", {dma_n, cpu_halt}, 2'b01);
  endtask

  task automatic t_multi();
    slot_req = 8'b0010_0100;
    strobe();
    check(grant == 8'b0000_0100, "R2 head wins", grant, 8'b0000_0100);
    check(chain_out[2] == 1'b0 && chain_out[5] == 1'b0 && chain_in[5] == 1'b0,
          "R7 block", {chain_in[5], chain_out[5], chain_out[2]}, '0);
    check(chain_out[1:0] == 2'b11, "R7 idle copy", chain_out, 8'b0000_0011);
  endtask

  task automatic t_hold_preempt();
    slot_req = 8'b0000_0010;
    @(negedge clk);
    @(negedge clk);
    check(grant == 8'b0000_0100, "R3 hold", grant, 8'b0000_0100);
    strobe();
    check(grant == 8'b0000_0010, "R9 preempt", grant, 8'b0000_0010);
  endtask

  task automatic t_pass();
    slot_dma_card = 8'b1111_1110;
    slot_req = 8'b0000_0001;
    strobe();
    check(grant == '0, "R5 req ignored", grant, '0);
    check(chain_out[0] == 1'b1 && chain_in[1] == 1'b1, "R5 pass",
          chain_out, 8'b1111_1111);
    slot_req = 8'b0000_0011;
    strobe();
    check(grant == 8'b0000_0010, "R5 downstream", grant, 8'b0000_0010);
    slot_dma_card = '1;
  endtask

  task automatic t_empty();
    slot_present = 8'b1111_1011;
    slot_req = 8'b0001_0000;
    strobe();
    check(grant == expect_grant(slot_present, slot_dma_card, slot_req) && grant == '0,
          "R6 gap", grant, '0);
    check(chain_out[2] == 1'b0 && chain_in[4] == 1'b0, "R6 chain",
          {chain_in[4], chain_out[2]}, '0);
    slot_req = 8'b0001_0010;
    strobe();
    check(grant == 8'b0000_0010, "R6 before gap", grant, 8'b0000_0010);
    slot_present = '1;
  endtask

  task automatic t_none();
    slot_req = '0;
    strobe();
    check(grant == '0, "R10 idle", grant, '0);
    check(dma_n == 1'b1 && cpu_halt == 1'b0, "R10 cpu owns", {dma_n, cpu_halt}, 2'b10);
  endtask

  task automatic t_all();
    slot_req = '1;
    strobe();
    check($countones(grant) == 1 && grant == 8'b0000_0001, "R4 all", grant, 8'b0000_0001);
    slot_req = 8'b1000_0000;
    strobe();
    check(grant == 8'b1000_0000, "R2 tail", grant, 8'b1000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_hold_preempt();
    t_pass();
    t_empty();
    t_none();
    t_all();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule